// File: doc/BRIEF.md
# PWM Sound Clip Player

This block plays short sound effects as a one-bit pulse-width bit stream. Two clips of 8-bit unsigned levels sit in two separate on-chip sample banks. Software issues a single control write that names a clip and asks for it to start. The player then steps through that clip's levels one by one, at the audio sample rate, until the clip's last level has been held for its full period. It then goes quiet.

A free-running 8-bit counter is compared against the current level on every clock. The output bit is high while the counter is below the level, so the fraction of high cycles in each 256-cycle period equals the level over 256. The stream is meant to feed an external low-pass filter and amplifier. The sound is mono: the left and right pins carry the same bit. With a 100 MHz clock, the default divide ratio of 12500 gives an 8 kHz sample rate.

The sample banks are modelled as small arrays, with contents computed from the address. A start request issued while a clip is playing aborts that clip and begins the newly named clip from its first level.

Top module: `pwm_clip_player`

## Requirements
- R1: While reset is asserted, and after it is released with no control write, `busy` is 0 and both PWM outputs are 0.
- R2: A cycle with `ctl_wr`=1 and `ctl_data[1]`=1 starts playback at the next clock edge. `busy` rises at that edge and the level address restarts at 0. `ctl_data[0]` picks the clip: 0 selects bank 0 and 1 selects bank 1.
- R3: Each level is held for exactly `CLK_DIV` cycles, and addresses advance by one, in order, from 0.
- R4: Over any 256 consecutive cycles during which one level L drives the modulator, the output is high for exactly L cycles. A level of 0 gives a constant low output.
- R5: Bank 0 holds level (a*37) mod 256 at address a. Bank 1 holds level 255 - ((a*23) mod 256). The clips are `CLIP0_LEN` and `CLIP1_LEN` levels long.
- R6: A clip started at edge E ends at edge E + LEN*`CLK_DIV`, where `busy` falls. From the following cycle on, the outputs stay low until the next start.
- R7: A start request made during playback takes effect at the next edge. The newly selected clip then plays from address 0 for its full length, measured from that edge.
- R8: A control write with `ctl_data[1]`=0 has no effect. It neither starts an idle player nor changes the clip or the timing of one that is playing.
- R9: `pwm_left` and `pwm_right` are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_wr | input | 1 | Control write strobe, one cycle |
| ctl_data | input | 2 | Control value: bit 1 requests a start, bit 0 selects the clip |
| busy | output | 1 | High while a clip is playing |
| pwm_left | output | 1 | PWM bit stream, left channel |
| pwm_right | output | 1 | PWM bit stream, right channel (same as left) |

## Verification
Let E be the edge that samples a start write. `busy` is high from E on, and it falls at E + LEN*`CLK_DIV`. Because the comparator output is registered, level k controls the output bit from edge E + k*`CLK_DIV` + 1 up to edge E + (k+1)*`CLK_DIV`. The bench drives and samples only on falling edges and counts cycles from E. It measures each duty cycle over a 256-cycle window that starts 100 cycles into that span, and it checks `busy` one cycle before and at the cycle of its fall. The bench uses a reduced divide ratio and short clips, so that every level of each clip, the restart case and the ignored writes all fit in a short run.

// File: rtl/pwm_player_pkg.sv
package pwm_player_pkg;

  localparam int LEVEL_W = 8;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_PLAY = 1'b1
  } phase_e;

  // Stored clip contents, computed from the address.
  function automatic logic [LEVEL_W-1:0] clip_level(input int bank, input int idx);
    logic [15:0] prod;
    if (bank == 0) begin
      prod = 16'(idx * 37);
      return prod[7:0];
    end else begin
      prod = 16'(idx * 23);
      return 8'(8'hFF - prod[7:0]);
    end
  endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int CLK_DIV = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && (cnt_q == TOP);
  assign cnt_en = clear || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || !run)    cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clip_sequencer.sv
module clip_sequencer
  import pwm_player_pkg::*;
#(
  parameter int CLIP0_LEN = 32,
  parameter int CLIP1_LEN = 48,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_data,
  input  logic          tick,
  output phase_e        phase_o,
  output logic          sel_o,
  output logic [AW-1:0] addr_o,
  output logic          restart_o
);
  localparam logic [AW-1:0] LAST0 = AW'(CLIP0_LEN - 1);
  localparam logic [AW-1:0] LAST1 = AW'(CLIP1_LEN - 1);

  phase_e        phase_q, phase_d;
  logic          sel_q, sel_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] last_addr;
  logic          upd_en;

  assign restart_o = wr_en && wr_data[1];
  assign last_addr = sel_q ? LAST1 : LAST0;
  assign upd_en    = restart_o || (phase_q == PH_PLAY && tick);

  always_comb begin
    phase_d = phase_q;
    sel_d   = sel_q;
    addr_d  = addr_q;
    if (restart_o) begin
      phase_d = PH_PLAY;
      sel_d   = wr_data[0];
      addr_d  = '0;
    end else if (phase_q == PH_PLAY && tick) begin
      if (addr_q == last_addr) begin
        phase_d = PH_IDLE;
        addr_d  = '0;
      end else begin
        addr_d  = addr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sel_q   <= 1'b0;
      addr_q  <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      sel_q   <= sel_d;
      addr_q  <= addr_d;
    end
  end

  assign phase_o = phase_q;
  assign sel_o   = sel_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/sample_rom.sv
module sample_rom
  import pwm_player_pkg::*;
#(
  parameter int BANK  = 0,
  parameter int DEPTH = 32,
  parameter int AW    = 6
) (
  input  logic [AW-1:0]      addr,
  output logic [LEVEL_W-1:0] level
);
  localparam int SLOTS = 1 << AW;

  logic [LEVEL_W-1:0] mem [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_fill
    if (i < DEPTH) begin : g_used
      assign mem[i] = clip_level(BANK, i);
    end else begin : g_pad
      assign mem[i] = '0;
    end
  end

  assign level = mem[addr];
endmodule

// File: rtl/pwm_modulator.sv
module pwm_modulator
  import pwm_player_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [LEVEL_W-1:0] level,
  output logic               pwm
);
  logic [LEVEL_W-1:0] ramp_q, ramp_d;
  logic               pwm_q, pwm_d;

  always_comb begin
    ramp_d = clear ? '0 : ramp_q + LEVEL_W'(1);
    pwm_d  = (ramp_q < level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      ramp_q <= ramp_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm_clip_player.sv
module pwm_clip_player
  import pwm_player_pkg::*;
#(
  parameter int CLK_DIV   = 12500,
  parameter int CLIP0_LEN = 32,
  parameter int CLIP1_LEN = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_data,
  output logic       busy,
  output logic       pwm_left,
  output logic       pwm_right
);
  localparam int MAXLEN = (CLIP0_LEN > CLIP1_LEN) ? CLIP0_LEN : CLIP1_LEN;
  localparam int AW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam int NBANK  = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  phase_e             seq_phase;
  logic               seq_sel;
  logic [AW-1:0]      seq_addr;
  logic               seq_restart;
  logic               div_tick;
  logic               playing;
  logic [LEVEL_W-1:0] bank_level [NBANK];
  logic [LEVEL_W-1:0] drive_level;
  logic               pwm_bit;

  assign playing = (seq_phase == PH_PLAY);

  rate_divider #(.CLK_DIV(CLK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (seq_restart),
    .run   (playing),
    .tick  (div_tick)
  );

  clip_sequencer #(
    .CLIP0_LEN (CLIP0_LEN),
    .CLIP1_LEN (CLIP1_LEN),
    .AW        (AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (ctl_wr),
    .wr_data   (ctl_data),
    .tick      (div_tick),
    .phase_o   (seq_phase),
    .sel_o     (seq_sel),
    .addr_o    (seq_addr),
    .restart_o (seq_restart)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sample_rom #(
      .BANK  (b),
      .DEPTH ((b == 0) ? CLIP0_LEN : CLIP1_LEN),
      .AW    (AW)
    ) u_rom (
      .addr  (seq_addr),
      .level (bank_level[b])
    );
  end

  always_comb begin
    drive_level = '0;
    if (playing) drive_level = bank_level[seq_sel];
  end

  pwm_modulator u_pwm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (seq_restart),
    .level (drive_level),
    .pwm   (pwm_bit)
  );

  assign busy      = playing;
  assign pwm_left  = pwm_bit;
  assign pwm_right = pwm_bit;
endmodule

// File: rtl/pwm_clip_player_chk.sv
module pwm_clip_player_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [1:0]    ctl_data,
  input logic          busy,
  input logic          pwm_left,
  input logic          pwm_right,
  input logic [AW-1:0] addr,
  input logic          tick
);
  logic start_req;
  assign start_req = ctl_wr && ctl_data[1];

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> busy);

  assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (addr == '0));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start_req) && (addr != $past(addr)))
      |-> (addr == $past(addr) + AW'(1)));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !start_req) |=> $stable(addr));

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !pwm_left);

  assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_data[1] && !busy) |=> !busy);

  assert_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_left == pwm_right);
endmodule

bind pwm_clip_player pwm_clip_player_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctl_wr    (ctl_wr),
  .ctl_data  (ctl_data),
  .busy      (busy),
  .pwm_left  (pwm_left),
  .pwm_right (pwm_right),
  .addr      (seq_addr),
  .tick      (div_tick)
);

// File: tb/pwm_clip_player_tb.sv
module pwm_clip_player_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 1024;
  localparam int LEN0 = 4;
  localparam int LEN1 = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [1:0] ctl_data = 2'b00;
  logic       busy, pwm_left, pwm_right;

  int tests_run = 0;
  int tests_failed = 0;
  int pos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_clip_player #(.CLK_DIV(DIV), .CLIP0_LEN(LEN0), .CLIP1_LEN(LEN1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .busy(busy), .pwm_left(pwm_left), .pwm_right(pwm_right)
  );

  function automatic int exp_level(input int b, input int k);
    if (b == 0) return (k * 37) % 256;
    return 255 - ((k * 23) % 256);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pos++;
  endtask

  task automatic wait_to(input int p);
    while (pos < p) step();
  endtask

  // Write issued at a falling edge; pos becomes 0 half a cycle after the sampling edge.
  task automatic write_ctl(input logic [1:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_data = d;
    @(negedge clk);
    ctl_wr = 1'b0;
    pos = 0;
  endtask

  task automatic measure(output int hi, output int mism);
    hi = 0;
    mism = 0;
    for (int i = 0; i < 256; i++) begin
      step();
      if (pwm_left) hi++;
      if (pwm_left != pwm_right) mism++;
    end
  endtask

  task automatic check_level(input int b, input int k, input int exp, input string tag);
    int hi, mism;
    wait_to(k * DIV + 100);
    measure(hi, mism);
    check({tag, " duty"}, hi, exp);
    check("R9 mirror", mism, 0);
    check({tag, " busy"}, int'(busy), 1);
  endtask

  task automatic check_end(input int len, input string tag);
    int hi, mism;
    wait_to(len * DIV - 1);
    check({tag, " busy before end"}, int'(busy), 1);
    step();
    check({tag, " busy at end"}, int'(busy), 0);
    step();
    measure(hi, mism);
    check("R6 low when idle", hi, 0);
  endtask

  task automatic test_reset();
    check("R1 busy in reset", int'(busy), 0);
    check("R1 pwm in reset", int'(pwm_left | pwm_right), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 pwm after reset", int'(pwm_left | pwm_right), 0);
  endtask

  task automatic test_clip(input int b, input int len);
    write_ctl({1'b1, b[0]});
    for (int k = 0; k < len; k++)
      check_level(b, k, exp_level(b, k), (k == 0 && b == 0) ? "R4 zero level" : "R2 R3 R5 level");
    check_end(len, "R6");
  endtask

  task automatic test_restart();
    write_ctl(2'b10);
    check_level(0, 1, exp_level(0, 1), "R7 before restart");
    write_ctl(2'b11);
    check_level(1, 0, exp_level(1, 0), "R7 new clip level0");
    check_level(1, 1, exp_level(1, 1), "R7 new clip level1");
    check_end(LEN1, "R7");
  endtask

  task automatic test_ignore();
    int hi, mism;
    write_ctl(2'b01);
    repeat (5) step();
    check("R8 idle stays idle", int'(busy), 0);
    measure(hi, mism);
    check("R8 idle output low", hi, 0);
    write_ctl(2'b11);
    check_level(1, 0, exp_level(1, 0), "R8 playing");
    wait_to(DIV / 2);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_data = 2'b00;
    @(negedge clk);
    ctl_wr = 1'b0;
    pos += 2;
    check_level(1, 1, exp_level(1, 1), "R8 clip unchanged");
    check_end(LEN1, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    test_reset();
    test_clip(0, LEN0);
    test_clip(1, LEN1);
    test_restart();
    test_ignore();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule